// File: doc/BRIEF.md
# RAM Overlay Flash Address Remapper

This block sits on a 24-bit CPU address bus and steers each access to either on-chip RAM or on-chip flash. A small byte-wide control register holds an overlay enable and a 3-bit block number. With the overlay on, any access that lands in the chosen 512-byte block of the flash region 0x01F000–0x01FFFF is redirected to a fixed 512-byte RAM window. Software can then tune constants in RAM as though they lived in flash, without waiting for erase and program cycles. The window is still reachable at its home address 0xFFF000–0xFFF1FF, so the same bytes appear under two addresses.

The register can be changed only in the operating modes that enable on-chip flash. It carries a sticky read-only flash error flag. A reset or hardware standby clears it, and software standby leaves it as it is. The address decode is combinational from the current register contents. The flash and RAM arrays are outside this block.

Top module: `ovl_remap`

## Requirements
- R1: After `rst_n` goes low, or after any clock edge at which `hw_stby` is high, `reg_rdata` reads 0x70: flag clear, overlay off, block number 0.
- R2: Bits 6..4 of `reg_rdata` always read as 1.
- R3: A write (`reg_we` high at a clock edge) loads `reg_wdata[3]` as the enable and `reg_wdata[2:0]` as the block number only while `mode` is 5, 6 or 7. In any other mode the write is ignored, bits 3..0 read as 0 and no remap takes place. The stored value reappears once the mode returns to 5..7.
- R4: Bit 7 of `reg_rdata` is the flash error flag. Writing to it has no effect. It is set at the first clock edge at which `flash_err` is high and stays set until R1 clears it.
- R5: While the enable is 0, addresses in 0x01F000–0x01FFFF select flash, whatever the block number.
- R6: While the enable is 1, an access in 0x01F000 + n×0x200 to 0x01F000 + n×0x200 + 0x1FF, where n is the block number, raises `ram_sel`, lowers `flash_sel` and drives `ram_off` with address bits 8..0.
- R7: With the overlay on, flash addresses outside the chosen block, including the other seven overlay blocks, still select flash. `ram_sel` and `flash_sel` are never high together.
- R8: An access in 0xFFF000–0xFFF1FF raises `ram_sel` with `ram_off` equal to address bits 8..0, whether the overlay is on or off.
- R9: `sw_stby` leaves the register contents unchanged, and while it is high neither select is raised.
- R10: A register write changes the decode of accesses presented from the next cycle on.
- R11: With `bus_valid` low, or with an address outside flash (0x000000–0x01FFFF) and outside the window, both selects are low and `ram_off` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby; clears the register at the clock edge |
| sw_stby | input | 1 | Software standby; keeps the register and suppresses selects |
| mode | input | 3 | Operating mode; 5..7 allow register writes |
| flash_err | input | 1 | Flash error event; sets the sticky flag |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| bus_valid | input | 1 | An access is present on the bus |
| bus_addr | input | 24 | Access address |
| ram_sel | output | 1 | Access goes to the overlay RAM window |
| flash_sel | output | 1 | Access goes to flash |
| ram_off | output | 9 | Byte offset inside the RAM window |

## Verification
The properties assume that `mode` changes only between clock edges and that `hw_stby` and `rst_n` are the only ways to clear state. They also assume that `flash_err` is a level sampled at the clock, not a glitch. The stimulus follows these assumptions. Every input is driven at the falling edge, so each change is sampled by exactly one rising edge. Mode and standby changes are made in cycles of their own, apart from register writes. This keeps each expected register value traceable to a single edge. Bus addresses are probed one per cycle, at the first and last byte of a block and at points inside it, so the block boundary decode is exercised on both sides.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int BLK_W = 3;

    typedef struct packed {
        logic             err;
        logic             en;
        logic [BLK_W-1:0] blk;
    } ovl_state_t;
endpackage

// File: rtl/ovl_ctlreg.sv
module ovl_ctlreg
    import ovl_pkg::*;
#(
    parameter int MODE_W  = 3,
    parameter int MODE_LO = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic [MODE_W-1:0] mode,
    input  logic              flash_err,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              eff_en,
    output logic [BLK_W-1:0]  eff_blk
);
    localparam int EN_BIT = BLK_W;

    ovl_state_t st_d, st_q;
    logic       wr_ok;

    assign wr_ok = (int'(mode) >= MODE_LO);

    always_comb begin
        st_d = st_q;
        if (flash_err) begin
            st_d.err = 1'b1;
        end
        if (we && wr_ok) begin
            st_d.en  = wdata[EN_BIT];
            st_d.blk = wdata[BLK_W-1:0];
        end
        if (hw_stby) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata         = 8'h70;
        rdata[7]      = st_q.err;
        if (wr_ok) begin
            rdata[EN_BIT]      = st_q.en;
            rdata[BLK_W-1:0]   = st_q.blk;
        end
        eff_en  = wr_ok & st_q.en;
        eff_blk = st_q.blk;
    end
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode #(
    parameter int              ADDR_W     = 24,
    parameter int              OFF_W      = 9,
    parameter int              BLK_W      = 3,
    parameter logic [23:0]     WIN_BASE   = 24'hFFF000,
    parameter logic [23:0]     OVL_BASE   = 24'h01F000,
    parameter logic [23:0]     FLASH_LAST = 24'h01FFFF
) (
    input  logic              valid,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [BLK_W-1:0]  blk,
    output logic              ram_sel,
    output logic              flash_sel,
    output logic [OFF_W-1:0]  ram_off
);
    localparam int REG_LO = OFF_W + BLK_W;

    logic hit_win, hit_ovl, hit_flash, live;

    always_comb begin
        live      = valid & ~sleep;
        hit_win   = (addr[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]);
        hit_ovl   = en
                  && (addr[ADDR_W-1:REG_LO] == OVL_BASE[ADDR_W-1:REG_LO])
                  && (addr[OFF_W +: BLK_W] == blk);
        hit_flash = (addr <= FLASH_LAST[ADDR_W-1:0]);

        ram_sel   = live & (hit_win | hit_ovl);
        flash_sel = live & hit_flash & ~hit_ovl;
        ram_off   = ram_sel ? addr[OFF_W-1:0] : '0;
    end
endmodule

// File: rtl/ovl_remap.sv
module ovl_remap
    import ovl_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          OFF_W      = 9,
    parameter int          MODE_W     = 3,
    parameter int          MODE_LO    = 5,
    parameter logic [23:0] WIN_BASE   = 24'hFFF000,
    parameter logic [23:0] OVL_BASE   = 24'h01F000,
    parameter logic [23:0] FLASH_LAST = 24'h01FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [MODE_W-1:0] mode,
    input  logic              flash_err,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              ram_sel,
    output logic              flash_sel,
    output logic [OFF_W-1:0]  ram_off
);
    logic             eff_en;
    logic [BLK_W-1:0] eff_blk;

    ovl_ctlreg #(
        .MODE_W  (MODE_W),
        .MODE_LO (MODE_LO)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_stby   (hw_stby),
        .mode      (mode),
        .flash_err (flash_err),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .eff_en    (eff_en),
        .eff_blk   (eff_blk)
    );

    ovl_decode #(
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W),
        .BLK_W      (BLK_W),
        .WIN_BASE   (WIN_BASE),
        .OVL_BASE   (OVL_BASE),
        .FLASH_LAST (FLASH_LAST)
    ) u_dec (
        .valid     (bus_valid),
        .sleep     (sw_stby),
        .addr      (bus_addr),
        .en        (eff_en),
        .blk       (eff_blk),
        .ram_sel   (ram_sel),
        .flash_sel (flash_sel),
        .ram_off   (ram_off)
    );
endmodule

// File: rtl/ovl_remap_chk.sv
module ovl_remap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hw_stby,
    input logic        sw_stby,
    input logic [2:0]  mode,
    input logic        flash_err,
    input logic        reg_we,
    input logic [7:0]  reg_rdata,
    input logic        bus_valid,
    input logic [23:0] bus_addr,
    input logic        ram_sel,
    input logic        flash_sel,
    input logic [8:0]  ram_off
);
    a_r2_reserved_ones: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:4] == 3'b111);

    a_r1_hw_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (reg_rdata == 8'h70));

    a_r3_locked_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode < 3'd5) |-> (reg_rdata[3:0] == 4'h0));

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !hw_stby && mode >= 3'd5) |=>
            (mode < 3'd5 || $stable(reg_rdata[3:0])));

    a_r4_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_err && !hw_stby) |=> reg_rdata[7]);

    a_r6_overlay_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !sw_stby && reg_rdata[3]
         && bus_addr[23:12] == 12'h01F && bus_addr[11:9] == reg_rdata[2:0])
        |-> (ram_sel && !flash_sel && ram_off == bus_addr[8:0]));

    a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_sel && flash_sel));

    a_r9_quiet_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stby |-> (!ram_sel && !flash_sel));
endmodule

bind ovl_remap ovl_remap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .mode      (mode),
    .flash_err (flash_err),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .ram_sel   (ram_sel),
    .flash_sel (flash_sel),
    .ram_off   (ram_off)
);

// File: tb/tb_ovl_remap.sv
module tb_ovl_remap;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_stby = 1'b0;
    logic        sw_stby = 1'b0;
    logic [2:0]  mode = 3'd7;
    logic        flash_err = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = 24'h0;
    logic        ram_sel, flash_sel;
    logic [8:0]  ram_off;

    always #(PERIOD/2) clk = ~clk;

    ovl_remap dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .mode(mode), .flash_err(flash_err), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .ram_sel(ram_sel), .flash_sel(flash_sel),
        .ram_off(ram_off)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       rs;
        logic       fs;
        logic [8:0] off;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // bench model of the register, from the requirements
    logic [3:0] m_ctl = 4'h0;
    logic       m_err = 1'b0;

    function automatic exp_t predict(string tag);
        exp_t e;
        logic ok, en, hit_ovl, hit_win, live;
        ok      = (mode >= 3'd5);
        en      = ok && m_ctl[3];
        live    = bus_valid && !sw_stby;
        hit_win = (bus_addr >= 24'hFFF000) && (bus_addr <= 24'hFFF1FF);
        hit_ovl = en && (bus_addr >= 24'h01F000 + {12'h0, m_ctl[2:0], 9'h0})
                     && (bus_addr <= 24'h01F1FF + {12'h0, m_ctl[2:0], 9'h0});
        e.tag = tag;
        e.rd  = {m_err, 3'b111, ok ? m_ctl : 4'h0};
        e.rs  = live && (hit_win || hit_ovl);
        e.fs  = live && (bus_addr <= 24'h01FFFF) && !hit_ovl;
        e.off = e.rs ? bus_addr[8:0] : 9'h0;
        return e;
    endfunction

    task automatic probe(input logic v, input logic [23:0] a, input string tag);
        @(negedge clk);
        bus_valid = v;
        bus_addr  = a;
        exp_q.push_back(predict(tag));
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (mode >= 3'd5) m_ctl = d[3:0];
        exp_q.push_back(predict("R10 write visible next cycle"));
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode = m;
    endtask

    // monitor: compares a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (reg_rdata !== e.rd || ram_sel !== e.rs || flash_sel !== e.fs
                    || ram_off !== e.off) begin
                    n_fail++;
                    $display("FAIL %s: got rd=%h ram=%b fl=%b off=%h exp rd=%h ram=%b fl=%b off=%h",
                             e.tag, reg_rdata, ram_sel, flash_sel, ram_off,
                             e.rd, e.rs, e.fs, e.off);
                end
            end
        end
    end

    initial begin
        #(PERIOD*20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        probe(1'b0, 24'h0, "R1 reset value 0x70 and R2 reserved ones");
        probe(1'b1, 24'h01F000, "R5 overlay off after reset");

        wr(8'h03);
        probe(1'b1, 24'h01F600, "R5 block number ignored while disabled");
        probe(1'b1, 24'hFFF0A5, "R8 window reachable with overlay off");

        for (int b = 0; b < 8; b++) begin
            logic [23:0] base;
            base = 24'h01F000 + 24'(b) * 24'h200;
            wr(8'h08 | 8'(b));
            probe(1'b1, base, "R6 first byte of chosen block");
            probe(1'b1, base + 24'h1FF, "R6 last byte of chosen block");
            probe(1'b1, base + 24'(b * 37 + 5), "R6 inside chosen block");
            probe(1'b1, 24'h01F000 + 24'((b + 1) % 8) * 24'h200 + 24'h10,
                  "R7 other overlay block stays flash");
            probe(1'b1, 24'hFFF000 + 24'(b * 61), "R8 window alias while overlaid");
        end
        probe(1'b1, 24'h01EFFF, "R7 flash just below region");
        probe(1'b1, 24'h000100, "R7 low flash");

        wr(8'h8D);
        probe(1'b0, 24'h0, "R4 write to flag bit ignored");
        @(negedge clk); flash_err = 1'b1;
        @(negedge clk); flash_err = 1'b0; m_err = 1'b1;
        probe(1'b0, 24'h0, "R4 flag set by flash error");
        probe(1'b0, 24'h0, "R4 flag sticky");

        @(negedge clk); sw_stby = 1'b1;
        probe(1'b1, 24'h01FA40, "R9 no selects in software standby");
        probe(1'b1, 24'hFFF040, "R9 window quiet in software standby");
        @(negedge clk); sw_stby = 1'b0;
        probe(1'b1, 24'h01FA40, "R9 register kept across software standby");

        set_mode(3'd3);
        probe(1'b1, 24'h01FA40, "R3 locked mode reads zero and no remap");
        wr(8'h09);
        probe(1'b1, 24'h01F200, "R3 write ignored in locked mode");
        set_mode(3'd4);
        probe(1'b1, 24'h01FA00, "R3 mode 4 still locked");
        set_mode(3'd5);
        probe(1'b1, 24'h01FA00, "R3 stored value returns in mode 5");
        wr(8'h0E);
        probe(1'b1, 24'h01FC80, "R3 write accepted in mode 5");
        set_mode(3'd7);

        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk); hw_stby = 1'b0; m_ctl = 4'h0; m_err = 1'b0;
        probe(1'b1, 24'h01FC80, "R1 hardware standby clears register");

        wr(8'h0B);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; m_ctl = 4'h0;
        probe(1'b1, 24'h01F600, "R1 reset clears register");

        probe(1'b1, 24'h400000, "R11 unmapped address selects nothing");
        probe(1'b1, 24'hFFF200, "R11 just above window");
        probe(1'b0, 24'hFFF010, "R11 no access when bus idle");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule